// File: doc/BRIEF.md
# Pointer-Update Hazard Checker

This block sits beside an instruction pipeline and looks at one decoded instruction per valid cycle. It reports the case where an instruction reads a pointer register that the previous instruction has just rewritten. A pipelined core cannot yet see that new value, so the reading instruction would use the old one. Three pointer classes are tracked: the register-bank base (context) pointer, a set of data page pointers, and the stack pointer. A context-switch instruction that loads a new bank base counts as a context-pointer write.

Each pointer class has its own kind of consumer. After a context-pointer write, only instructions that address a general-purpose register are at risk. After a page-pointer write, only instructions that use that same page pointer implicitly, through long or indirect addressing, are at risk. After a stack-pointer write, only return and pop instructions are at risk. The block only detects and reports the hazard. Stalling the pipeline, decoding instructions and accessing memory are the job of the surrounding logic.

Top module: `ptr_hazard_detect`

## Requirements
- R1: A valid instruction with `uses_gpr` high that directly follows a valid instruction with `wr_ctx` high raises a hazard of class 2'b01. A context switch is signalled on `wr_ctx`.
- R2: A valid instruction with `page_use_en` high whose `page_use_idx` equals the index the previous valid instruction wrote (`wr_page_en` high, `wr_page_idx`) raises a hazard of class 2'b10. `hazard_page_idx` then carries that index.
- R3: A page-pointer write followed by an implicit use of a different page-pointer index raises no hazard.
- R4: A page-pointer write followed by an instruction with `page_use_en` low raises no hazard, even if that instruction uses a general-purpose register.
- R5: A valid instruction with `is_stack_pop` high (any return or pop) that directly follows a valid instruction with `wr_stack` high raises a hazard of class 2'b11.
- R6: One valid instruction that writes no pointer, placed between the writer and the user, removes the hazard.
- R7: Cycles with `instr_valid` low neither replace nor clear the remembered previous instruction.
- R8: When several classes apply in the same cycle, the context class wins over the page class, and the page class wins over the stack class. `hazard_page_idx` is 0 unless the reported class is 2'b10.
- R9: The outputs are registered. The result for an instruction appears in the cycle after it is presented and lasts one cycle. `hazard_pulse` is high exactly when `hazard_class` is not 2'b00.
- R10: A synchronous active-low reset clears the remembered writes and the outputs. The first instruction after reset never raises a hazard.
- R11: An instruction that both writes a pointer and uses it is checked only against the previous instruction. Its own write affects only the next instruction.
- R12: A cycle with `instr_valid` low produces no hazard in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | An instruction is presented this cycle |
| wr_ctx | input | 1 | Instruction writes the register-bank base pointer (including a context switch) |
| wr_page_en | input | 1 | Instruction writes a page pointer |
| wr_page_idx | input | IDX_W | Index of the page pointer written |
| wr_stack | input | 1 | Instruction writes the stack pointer explicitly |
| uses_gpr | input | 1 | Instruction addresses a general-purpose register |
| page_use_en | input | 1 | Instruction uses a page pointer implicitly (long or indirect addressing) |
| page_use_idx | input | IDX_W | Index of the page pointer used |
| is_stack_pop | input | 1 | Instruction is a return or a pop |
| hazard_pulse | output | 1 | One-cycle hazard flag |
| hazard_class | output | 2 | 00 none, 01 context, 10 page, 11 stack |
| hazard_page_idx | output | IDX_W | Offending page-pointer index when the class is 10, otherwise 0 |

## Verification
The bench builds the block with the default of four page pointers, which gives a two-bit index. With that size it can write and then use every index, including the top index 3 and index 0. A use of a neighbouring index lands on a different per-index comparator, so a wrong-index match becomes observable. The shared-cycle cases, where one instruction hits several classes at once, show both priority orders and the zero page index reported under a context-class win.

// File: rtl/ptr_hazard_pkg.sv
// Package: shared hazard class encoding for the pointer-update checker.
package ptr_hazard_pkg;
    typedef enum logic [1:0] {
        HZ_NONE  = 2'b00,
        HZ_CTX   = 2'b01,
        HZ_PAGE  = 2'b10,
        HZ_STACK = 2'b11
    } hz_class_e;
endpackage

// File: rtl/hz_history.sv
// Module: hz_history
// Remembers which pointers the last valid instruction wrote.
// Assumes at most one page-pointer index is written per instruction.
// Cycles without a valid instruction hold the stored state.
module hz_history #(
    parameter int NUM_DPP = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic               wr_ctx,
    input  logic               wr_page_en,
    input  logic [IDX_W-1:0]   wr_page_idx,
    input  logic               wr_stack,
    output logic               prev_ctx_wr,
    output logic [NUM_DPP-1:0] prev_page_wr,
    output logic               prev_stack_wr
);
    logic [NUM_DPP-1:0] page_dec;

    // Turn the written page index into a one-hot vector.
    for (genvar g = 0; g < NUM_DPP; g++) begin : g_dec
        assign page_dec[g] = wr_page_en && (wr_page_idx == IDX_W'(g));
    end

    // Store the write flags of each valid instruction; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ctx_wr   <= 1'b0;
            prev_page_wr  <= '0;
            prev_stack_wr <= 1'b0;
        end else if (instr_valid) begin
            prev_ctx_wr   <= wr_ctx;
            prev_page_wr  <= page_dec;
            prev_stack_wr <= wr_stack;
        end
    end
endmodule

// File: rtl/hz_detect.sv
// Module: hz_detect
// Combinational matching of the current instruction's register uses
// against the previous instruction's writes. There is one comparator per
// page pointer. Assumes the history inputs come from hz_history.
module hz_detect #(
    parameter int NUM_DPP = 4,
    parameter int IDX_W   = 2
) (
    input  logic               instr_valid,
    input  logic               uses_gpr,
    input  logic               page_use_en,
    input  logic [IDX_W-1:0]   page_use_idx,
    input  logic               is_stack_pop,
    input  logic               prev_ctx_wr,
    input  logic [NUM_DPP-1:0] prev_page_wr,
    input  logic               prev_stack_wr,
    output logic               ctx_hit,
    output logic [NUM_DPP-1:0] page_hit,
    output logic               stack_hit
);
    // Per-index page hazard: same pointer, implicit use only.
    for (genvar g = 0; g < NUM_DPP; g++) begin : g_page
        assign page_hit[g] = instr_valid && page_use_en &&
                             (page_use_idx == IDX_W'(g)) && prev_page_wr[g];
    end

    // Context and stack hazard terms.
    always_comb begin
        ctx_hit   = instr_valid && uses_gpr && prev_ctx_wr;
        stack_hit = instr_valid && is_stack_pop && prev_stack_wr;
    end
endmodule

// File: rtl/hz_report.sv
// Module: hz_report
// Prioritises the hazard terms (context, then page, then stack) and
// registers the pulse, the class and the page index.
// Assumes at most one bit of page_hit is set.
module hz_report
    import ptr_hazard_pkg::*;
#(
    parameter int NUM_DPP = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctx_hit,
    input  logic [NUM_DPP-1:0] page_hit,
    input  logic               stack_hit,
    output logic               hazard_pulse,
    output logic [1:0]         hazard_class,
    output logic [IDX_W-1:0]   hazard_page_idx
);
    hz_class_e        nxt_class;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] nxt_idx;

    // Encode the one-hot page hit into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_DPP; i++) begin
            if (page_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    // Fixed-priority class selection.
    always_comb begin
        nxt_idx = '0;
        if (ctx_hit) begin
            nxt_class = HZ_CTX;
        end else if (|page_hit) begin
            nxt_class = HZ_PAGE;
            nxt_idx   = hit_idx;
        end else if (stack_hit) begin
            nxt_class = HZ_STACK;
        end else begin
            nxt_class = HZ_NONE;
        end
    end

    // Register the outputs for one cycle per offending instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hazard_pulse    <= 1'b0;
            hazard_class    <= HZ_NONE;
            hazard_page_idx <= '0;
        end else begin
            hazard_pulse    <= ctx_hit || (|page_hit) || stack_hit;
            hazard_class    <= nxt_class;
            hazard_page_idx <= nxt_idx;
        end
    end
endmodule

// File: rtl/ptr_hazard_detect.sv
// Module: ptr_hazard_detect (top)
// Flags instructions that read a context, page or stack pointer written
// by the instruction just before them. Assumes one decoded instruction
// per valid cycle. Detection only; no stalling.
module ptr_hazard_detect #(
    parameter int NUM_DPP = 4,
    localparam int IDX_W  = (NUM_DPP > 1) ? $clog2(NUM_DPP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             wr_ctx,
    input  logic             wr_page_en,
    input  logic [IDX_W-1:0] wr_page_idx,
    input  logic             wr_stack,
    input  logic             uses_gpr,
    input  logic             page_use_en,
    input  logic [IDX_W-1:0] page_use_idx,
    input  logic             is_stack_pop,
    output logic             hazard_pulse,
    output logic [1:0]       hazard_class,
    output logic [IDX_W-1:0] hazard_page_idx
);
    logic               prev_ctx_wr;
    logic [NUM_DPP-1:0] prev_page_wr;
    logic               prev_stack_wr;
    logic               ctx_hit;
    logic [NUM_DPP-1:0] page_hit;
    logic               stack_hit;

    hz_history #(.NUM_DPP(NUM_DPP), .IDX_W(IDX_W)) history_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .wr_ctx       (wr_ctx),
        .wr_page_en   (wr_page_en),
        .wr_page_idx  (wr_page_idx),
        .wr_stack     (wr_stack),
        .prev_ctx_wr  (prev_ctx_wr),
        .prev_page_wr (prev_page_wr),
        .prev_stack_wr(prev_stack_wr)
    );

    hz_detect #(.NUM_DPP(NUM_DPP), .IDX_W(IDX_W)) detect_i (
        .instr_valid  (instr_valid),
        .uses_gpr     (uses_gpr),
        .page_use_en  (page_use_en),
        .page_use_idx (page_use_idx),
        .is_stack_pop (is_stack_pop),
        .prev_ctx_wr  (prev_ctx_wr),
        .prev_page_wr (prev_page_wr),
        .prev_stack_wr(prev_stack_wr),
        .ctx_hit      (ctx_hit),
        .page_hit     (page_hit),
        .stack_hit    (stack_hit)
    );

    hz_report #(.NUM_DPP(NUM_DPP), .IDX_W(IDX_W)) report_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctx_hit        (ctx_hit),
        .page_hit       (page_hit),
        .stack_hit      (stack_hit),
        .hazard_pulse   (hazard_pulse),
        .hazard_class   (hazard_class),
        .hazard_page_idx(hazard_page_idx)
    );
endmodule

// File: rtl/ptr_hazard_detect_chk.sv
// Module: ptr_hazard_detect_chk
// Assertion checker attached to ptr_hazard_detect through bind.
module ptr_hazard_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic       wr_ctx,
    input logic       wr_stack,
    input logic       uses_gpr,
    input logic       is_stack_pop,
    input logic       hazard_pulse,
    input logic [1:0] hazard_class
);
    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!hazard_pulse && hazard_class == 2'b00));

    assert_ctx_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && wr_ctx) ##1 (instr_valid && uses_gpr)
        |=> (hazard_pulse && hazard_class == 2'b01));

    assert_stack_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && wr_stack) ##1 (instr_valid && is_stack_pop)
        |=> (hazard_pulse && hazard_class != 2'b00));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !hazard_pulse);

    assert_pulse_matches_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_pulse == (hazard_class != 2'b00));
endmodule

bind ptr_hazard_detect ptr_hazard_detect_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .wr_ctx      (wr_ctx),
    .wr_stack    (wr_stack),
    .uses_gpr    (uses_gpr),
    .is_stack_pop(is_stack_pop),
    .hazard_pulse(hazard_pulse),
    .hazard_class(hazard_class)
);

// File: tb/ptr_hazard_detect_tb_top.sv
// Testbench: a vector table walked by one loop, then directed cases.
module ptr_hazard_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic       wr_ctx = 1'b0;
    logic       wr_page_en = 1'b0;
    logic [1:0] wr_page_idx = 2'd0;
    logic       wr_stack = 1'b0;
    logic       uses_gpr = 1'b0;
    logic       page_use_en = 1'b0;
    logic [1:0] page_use_idx = 2'd0;
    logic       is_stack_pop = 1'b0;
    logic       hazard_pulse;
    logic [1:0] hazard_class;
    logic [1:0] hazard_page_idx;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ptr_hazard_detect dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .wr_ctx(wr_ctx),
        .wr_page_en(wr_page_en), .wr_page_idx(wr_page_idx), .wr_stack(wr_stack),
        .uses_gpr(uses_gpr), .page_use_en(page_use_en), .page_use_idx(page_use_idx),
        .is_stack_pop(is_stack_pop), .hazard_pulse(hazard_pulse),
        .hazard_class(hazard_class), .hazard_page_idx(hazard_page_idx)
    );

    typedef struct packed {
        logic       v;
        logic       cp;
        logic       pw;
        logic [1:0] pwi;
        logic       sp;
        logic       g;
        logic       pu;
        logic [1:0] pui;
        logic       pop;
        logic       ep;
        logic [1:0] ec;
        logic [1:0] ei;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 25;
    // Fields: v cp pw pwi sp g pu pui pop | ep ec ei | requirement number
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,0,1,0,0,0, 0,0,0, 10}, // R10 first after reset
        '{1,1,0,0,0,0,0,0,0, 0,0,0,  9},
        '{1,0,0,0,0,1,0,0,0, 1,1,0,  1}, // R1
        '{1,0,0,0,0,1,0,0,0, 0,0,0,  9}, // R9 single cycle
        '{1,1,0,0,0,0,0,0,0, 0,0,0,  9},
        '{1,0,0,0,0,0,0,0,0, 0,0,0,  6},
        '{1,0,0,0,0,1,0,0,0, 0,0,0,  6}, // R6 spacer clears
        '{1,0,1,2,0,0,0,0,0, 0,0,0,  9},
        '{1,0,0,0,0,0,1,2,0, 1,2,2,  2}, // R2
        '{1,0,1,1,0,0,0,0,0, 0,0,0,  9},
        '{1,0,0,0,0,0,1,3,0, 0,0,0,  3}, // R3 other index
        '{1,0,1,0,0,0,0,0,0, 0,0,0,  9},
        '{1,0,0,0,0,1,0,0,0, 0,0,0,  4}, // R4 not an implicit user
        '{1,0,0,0,1,0,0,0,0, 0,0,0,  9},
        '{0,0,0,0,0,0,0,0,1, 0,0,0, 12}, // R12 idle
        '{1,0,0,0,0,0,0,0,1, 1,3,0,  7}, // R7 history kept over idle
        '{1,1,1,3,1,1,0,0,0, 0,0,0, 11}, // R11 own write not checked
        '{1,0,0,0,0,1,1,3,1, 1,1,0,  8}, // R8 context wins
        '{1,0,1,3,1,0,0,0,0, 0,0,0,  9},
        '{1,0,0,0,0,0,1,3,1, 1,2,3,  8}, // R8 page beats stack
        '{1,0,0,0,1,0,0,0,1, 0,0,0, 11},
        '{1,0,0,0,0,0,0,0,1, 1,3,0,  5}, // R5
        '{1,1,0,0,0,1,0,0,0, 0,0,0, 11},
        '{1,1,0,0,0,1,0,0,0, 1,1,0, 11}, // R11 checked vs previous
        '{1,0,0,0,0,1,0,0,0, 1,1,0,  1}  // R1 own write now seen
    };

    task automatic check(input string tag, input logic ep, input logic [1:0] ec,
                         input logic [1:0] ei);
        total++;
        if (hazard_pulse !== ep || hazard_class !== ec || hazard_page_idx !== ei) begin
            bad++;
            $display("FAIL %s: got pulse=%0b class=%0d idx=%0d, want pulse=%0b class=%0d idx=%0d",
                     tag, hazard_pulse, hazard_class, hazard_page_idx, ep, ec, ei);
        end
    endtask

    task automatic drive(input vec_t t);
        @(negedge clk);
        instr_valid  = t.v;   wr_ctx       = t.cp;
        wr_page_en   = t.pw;  wr_page_idx  = t.pwi;
        wr_stack     = t.sp;  uses_gpr     = t.g;
        page_use_en  = t.pu;  page_use_idx = t.pui;
        is_stack_pop = t.pop;
        @(posedge clk);
        #1;
    endtask

    function automatic vec_t mk(input logic cp, input logic pw, input logic [1:0] pwi,
                                input logic pu, input logic [1:0] pui, input logic g);
        vec_t t = '0;
        t.v = 1'b1; t.cp = cp; t.pw = pw; t.pwi = pwi; t.pu = pu; t.pui = pui; t.g = g;
        return t;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state", 1'b0, 2'd0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check($sformatf("R%0d row %0d", VEC[i].rq, i), VEC[i].ep, VEC[i].ec, VEC[i].ei);
        end

        // R2: every page index, written then used.
        for (int n = 0; n < 4; n++) begin
            drive(mk(1'b0, 1'b1, 2'(n), 1'b0, 2'd0, 1'b0));
            drive(mk(1'b0, 1'b0, 2'd0, 1'b1, 2'(n), 1'b0));
            check($sformatf("R2 index %0d", n), 1'b1, 2'd2, 2'(n));
        end

        // R10: reset between a context write and a register user.
        drive(mk(1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0));
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R10 outputs in reset", 1'b0, 2'd0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(mk(1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1));
        check("R10 history cleared", 1'b0, 2'd0, 2'd0);

        // R7: several idle cycles between page write and use.
        drive(mk(1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0));
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (3) @(posedge clk);
        drive(mk(1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0));
        check("R7 long idle gap", 1'b1, 2'd2, 2'd1);
        drive(mk(1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0));
        check("R9 pulse ends", 1'b0, 2'd0, 2'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule